// File: doc/BRIEF.md
# Serial Flash Bank Control Unit

This block sits between a simple register port, a memory-mapped bus requester and a two-bank serial flash. Software uses one 32-bit control word to choose which banks are enabled, which bank is the current target, and whether a write-enable command should be issued. The block drives one active-low chip-select per bank. Only one chip-select is ever active.

A bus transfer starts with a one-cycle `bus_req` and ends with a one-cycle `bus_end`. When the request is accepted, the selected bank is captured and its chip-select stays low until the transfer ends, whatever software writes in the meantime. A request aimed at a disabled or unimplemented bank is refused with a one-cycle error pulse, and no chip-select moves.

Software requests a write-enable command by writing 1 to the command bit. If the selected bank is enabled, the block shifts the opcode byte 8'h06 out over SPI mode 0 to that bank, then clears the bit. If the selected bank is disabled, the command is dropped without any error, and the bit clears one clock later.

Top module: `flash_bank_ctrl`

## Requirements
- R1: After reset the register reads 32'h0000_0001 (bank 0 enabled, bank 1 disabled, select 0, command bit 0), all chip-selects are high, `spi_sck` is low, and `bus_busy` and `bus_err` are low.
- R2: The register layout is enable field at bits [1:0] (bit n enables bank n), select field at bits [5:4], and command bit at bit 8. Every other bit reads 0 and ignores writes, and a write takes effect on the next read.
- R3: A `bus_req` sampled while idle, with the select field naming an enabled bank (00 is bank 0, 01 is bank 1), drives that bank's chip-select low and `bus_busy` high from the next cycle. Both return high or low one cycle after `bus_end` is sampled.
- R4: At most one chip-select is low at any time, and it is always the bank that was captured at the start of the operation.
- R5: A `bus_req` sampled while idle to a disabled bank, or with select 10 or 11, raises `bus_err` for exactly the next cycle and leaves all chip-selects high.
- R6: Register writes during a bus transfer or a command frame update the fields but do not change the chip-select of the operation in progress.
- R7: Writing 1 to the command bit, with an enabled bank selected, sends the byte 8'h06 MSB first in SPI mode 0 (SCK idle low, data stable while SCK is high). That bank's chip-select is held low for exactly 8 SCK periods, which is 16*SCK_HALF clock cycles.
- R8: The command bit reads 1 while the frame is pending or in flight and reads 0 from the cycle after the frame ends. With the default SCK_HALF=2, that is 33 cycles after the write was captured.
- R9: Writing 0 to the command bit has no effect: it neither clears a pending command nor aborts a frame.
- R10: Writing 1 to the command bit while the selected bank is disabled or unimplemented sends nothing (no chip-select, no SCK edge) and raises no error, and the bit reads 0 one cycle after the write.
- R11: A `bus_req` sampled while a transfer is already in progress is ignored: no error and no change of chip-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| bus_req | input | 1 | Start of a bus transfer (one-cycle pulse) |
| bus_end | input | 1 | End of the current bus transfer (one-cycle pulse) |
| bus_busy | output | 1 | A transfer or command frame is in progress |
| bus_err | output | 1 | One-cycle error response for a refused request |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | NUM_BANKS | Active-low chip-select, one bit per bank |

## Verification
Bus requests and command writes are applied under all sixteen combinations of the enable and select fields, both in directed cases and in seeded random order. Enabled targets, disabled targets and the two unimplemented select codes are told apart by whether a chip-select, an error pulse or a serial frame appears. Register writes issued in the middle of a transfer or a frame separate the captured bank from the live field. A zero write to the command bit in mid-frame separates a real no-op from an abort or clear. The serial frame is rebuilt from the SCK rising edges and checked for its byte value, edge count, chip-select length and the cycle at which the command bit clears.

// File: rtl/flash_bank_pkg.sv
// Package: shared constants and types for the serial flash bank control unit.
// Assumes the register fields below do not overlap for NUM_BANKS <= 4.
package flash_bank_pkg;
    localparam int REG_W      = 32;
    localparam int SEL_W      = 2;     // bank-select field width
    localparam int EN_LSB     = 0;     // bank-enable field position
    localparam int SEL_LSB    = 4;     // bank-select field position
    localparam int WEN_POS    = 8;     // write-enable command bit
    localparam logic [7:0] WREN_OPCODE = 8'h06;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BUS  = 2'd1,
        SEQ_CMD  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/fbc_regs.sv
// Module: control register holding bank enables, bank select and the
// self-clearing command bit. Writing 1 sets the command bit, writing 0
// leaves it alone, and wen_clr_i from the sequencer clears it. A set from
// software in the same cycle wins over the clear. Reserved bits read 0.
module fbc_regs
    import flash_bank_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [REG_W-1:0]     wdata_i,
    input  logic                 wen_clr_i,
    output logic [NUM_BANKS-1:0] en_o,
    output logic [SEL_W-1:0]     sel_o,
    output logic                 wen_o,
    output logic [REG_W-1:0]     rdata_o
);
    localparam logic [NUM_BANKS-1:0] EN_RESET = NUM_BANKS'(1);

    logic wen_set;
    assign wen_set = wr_i && wdata_i[WEN_POS];

    // Purpose: hold the enable and select fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= EN_RESET;
            sel_o <= '0;
        end else if (wr_i) begin
            en_o  <= wdata_i[EN_LSB +: NUM_BANKS];
            sel_o <= wdata_i[SEL_LSB +: SEL_W];
        end
    end

    // Purpose: command bit, set by software and cleared by hardware.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wen_o <= 1'b0;
        else if (wen_set)
            wen_o <= 1'b1;
        else if (wen_clr_i)
            wen_o <= 1'b0;
    end

    // Purpose: assemble the read word with the reserved bits at zero.
    always_comb begin
        rdata_o = '0;
        rdata_o[EN_LSB +: NUM_BANKS] = en_o;
        rdata_o[SEL_LSB +: SEL_W]    = sel_o;
        rdata_o[WEN_POS]             = wen_o;
    end

    AST_ZERO_WRITE_KEEPS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i[WEN_POS] && !wen_clr_i) |=> (wen_o == $past(wen_o))); // R9
endmodule

// File: rtl/fbc_spi_byte.sv
// Module: one-byte SPI mode 0 shifter. On start_i it loads byte_i and
// shifts it out MSB first. SCK toggles every HALF_CYC clocks and idles low.
// done_o pulses in the last busy cycle. Assumes start_i comes only while
// the shifter is idle.
module fbc_spi_byte #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

    logic [7:0]      shreg;
    logic [2:0]      bit_cnt;
    logic [HC_W-1:0] hc;
    logic            tick;

    assign tick   = busy_o && (hc == HC_LAST);
    assign done_o = tick && sck_o && (bit_cnt == 3'd7);
    assign mosi_o = shreg[7];

    // Purpose: half-period timer, SCK toggle and shift on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            sck_o   <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
            hc      <= '0;
        end else if (start_i && !busy_o) begin
            busy_o  <= 1'b1;
            sck_o   <= 1'b0;
            shreg   <= byte_i;
            bit_cnt <= '0;
            hc      <= '0;
        end else if (busy_o) begin
            if (tick) begin
                hc    <= '0;
                sck_o <= !sck_o;
                if (sck_o) begin
                    shreg   <= {shreg[6:0], 1'b0};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7)
                        busy_o <= 1'b0;
                end
            end else begin
                hc <= hc + HC_W'(1);
            end
        end
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sck_o); // R7
    AST_MOSI_HELD_HIGH_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sck_o) |-> $stable(mosi_o)); // R7
endmodule

// File: rtl/fbc_seq.sv
// Module: bank sequencer. While idle it accepts a bus request (checked
// first) or a pending command. It captures the bank select for the
// operation and drives that bank's chip-select. Bus requests to a disabled
// or unimplemented bank get a one-cycle error. Commands to such banks are
// dropped and their bit is cleared. Assumes spi_done_i pulses once per frame.
module fbc_seq
    import flash_bank_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] en_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic                 wen_i,
    input  logic                 bus_req_i,
    input  logic                 bus_end_i,
    input  logic                 spi_done_i,
    output logic                 spi_start_o,
    output logic                 wen_clr_o,
    output logic                 bus_err_o,
    output logic                 busy_o,
    output logic [NUM_BANKS-1:0] cs_n_o
);
    seq_state_t       state, state_d;
    logic [SEL_W-1:0] lat_bank, lat_d;
    logic             err_d;
    logic             bank_ok;

    // Purpose: decide whether the selected bank exists and is enabled.
    always_comb begin
        bank_ok = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (sel_i == SEL_W'(b) && en_i[b])
                bank_ok = 1'b1;
    end

    // Purpose: next-state, capture and command decisions.
    always_comb begin
        state_d     = state;
        lat_d       = lat_bank;
        err_d       = 1'b0;
        spi_start_o = 1'b0;
        wen_clr_o   = 1'b0;
        case (state)
            SEQ_IDLE: begin
                if (bus_req_i) begin
                    if (bank_ok) begin
                        state_d = SEQ_BUS;
                        lat_d   = sel_i;
                    end else begin
                        err_d = 1'b1;
                    end
                end else if (wen_i) begin
                    if (bank_ok) begin
                        state_d     = SEQ_CMD;
                        lat_d       = sel_i;
                        spi_start_o = 1'b1;
                    end else begin
                        wen_clr_o = 1'b1;
                    end
                end
            end
            SEQ_BUS: if (bus_end_i) state_d = SEQ_IDLE;
            SEQ_CMD: begin
                if (spi_done_i) begin
                    wen_clr_o = 1'b1;
                    state_d   = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Purpose: state, captured bank and error pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            lat_bank  <= '0;
            bus_err_o <= 1'b0;
        end else begin
            state     <= state_d;
            lat_bank  <= lat_d;
            bus_err_o <= err_d;
        end
    end

    assign busy_o = (state != SEQ_IDLE);

    // Purpose: one chip-select per bank, low only for the captured bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        assign cs_n_o[b] = !(busy_o && (lat_bank == SEL_W'(b)));
    end

    AST_ONE_CS_AT_MOST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o)); // R4
    AST_ERR_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> (&cs_n_o)); // R5
    AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(lat_bank))); // R6
    AST_WEN_SET_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_CMD) |-> wen_i); // R8
endmodule

// File: rtl/flash_bank_ctrl.sv
// Module: top of the serial flash bank control unit. It joins the control
// register, the bank sequencer and the one-byte SPI shifter. Assumes
// NUM_BANKS <= 4 and SCK_HALF >= 1. bus_req and bus_end are one-cycle pulses.
module flash_bank_ctrl
    import flash_bank_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int SCK_HALF  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 bus_req,
    input  logic                 bus_end,
    output logic                 bus_busy,
    output logic                 bus_err,
    output logic                 spi_sck,
    output logic                 spi_mosi,
    output logic [NUM_BANKS-1:0] spi_cs_n
);
    logic [NUM_BANKS-1:0] en;
    logic [SEL_W-1:0]     sel;
    logic                 wen, wen_clr, spi_start, spi_done, spi_busy;

    fbc_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .wdata_i(reg_wdata),
        .wen_clr_i(wen_clr), .en_o(en), .sel_o(sel), .wen_o(wen),
        .rdata_o(reg_rdata)
    );

    fbc_seq #(.NUM_BANKS(NUM_BANKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en), .sel_i(sel), .wen_i(wen),
        .bus_req_i(bus_req), .bus_end_i(bus_end), .spi_done_i(spi_done),
        .spi_start_o(spi_start), .wen_clr_o(wen_clr), .bus_err_o(bus_err),
        .busy_o(bus_busy), .cs_n_o(spi_cs_n)
    );

    fbc_spi_byte #(.HALF_CYC(SCK_HALF)) u_spi (
        .clk(clk), .rst_n(rst_n), .start_i(spi_start), .byte_i(WREN_OPCODE),
        .sck_o(spi_sck), .mosi_o(spi_mosi), .busy_o(spi_busy), .done_o(spi_done)
    );

    AST_SCK_ONLY_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !(&spi_cs_n)); // R7
    AST_SHIFTER_INSIDE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        spi_busy |-> bus_busy); // R4
endmodule

// File: tb/flash_bank_ctrl_bench.sv
module flash_bank_ctrl_bench;
    localparam int NB   = 2;
    localparam int HALF = 2;
    localparam int FRAME = 16 * HALF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, bus_req = 1'b0, bus_end = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic bus_busy, bus_err, spi_sck, spi_mosi;
    logic [NB-1:0] spi_cs_n;

    int n_chk = 0, n_fail = 0;
    logic [1:0] m_en, m_sel;

    always #5 clk = ~clk;

    flash_bank_ctrl #(.NUM_BANKS(NB), .SCK_HALF(HALF)) u_flash_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_end(bus_end),
        .bus_busy(bus_busy), .bus_err(bus_err), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    function automatic logic [31:0] exp_rd(logic [1:0] en, logic [1:0] sel, logic w);
        return (32'(w) << 8) | (32'(sel) << 4) | 32'(en);
    endfunction
    function automatic logic exp_ok(logic [1:0] en, logic [1:0] sel);
        return (sel < 2'd2) && en[sel[0]];
    endfunction
    function automatic logic [1:0] exp_cs(logic [1:0] sel);
        return ~(2'b01 << sel);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // R2: random reserved bits, command bit kept 0
    task automatic set_cfg(logic [1:0] en, logic [1:0] sel);
        logic [31:0] d;
        d = $urandom & ~32'h0000_0133;
        d = d | exp_rd(en, sel, 1'b0);
        reg_write(d);
        m_en = en; m_sel = sel;
        chk("R2 readback", reg_rdata, exp_rd(m_en, m_sel, 1'b0));
    endtask

    task automatic bus_op(bit mid);
        logic [1:0] s0; logic ok;
        ok = exp_ok(m_en, m_sel); s0 = m_sel;
        @(negedge clk); bus_req = 1'b1;
        @(negedge clk); bus_req = 1'b0;
        chk("R5 bus_err on request", 32'(bus_err), 32'(!ok));
        if (ok) begin
            chk("R3 cs low", 32'(spi_cs_n), 32'(exp_cs(s0)));
            chk("R3 busy", 32'(bus_busy), 32'd1);
            bus_req = 1'b1;
            @(negedge clk); bus_req = 1'b0;
            chk("R11 repeat req no err", 32'(bus_err), 32'd0);
            chk("R11 repeat req cs", 32'(spi_cs_n), 32'(exp_cs(s0)));
            if (mid) begin
                m_en = 2'($urandom); m_sel = 2'($urandom);
                reg_write(exp_rd(m_en, m_sel, 1'b0));
                chk("R6 cs held after write", 32'(spi_cs_n), 32'(exp_cs(s0)));
                chk("R2 fields updated", reg_rdata, exp_rd(m_en, m_sel, 1'b0));
            end
            bus_end = 1'b1;
            @(negedge clk); bus_end = 1'b0;
            chk("R3 cs released", 32'(spi_cs_n), 32'h3);
            chk("R3 busy released", 32'(bus_busy), 32'd0);
        end else begin
            chk("R5 no cs", 32'(spi_cs_n), 32'h3);
            @(negedge clk);
            chk("R5 err one cycle", 32'(bus_err), 32'd0);
        end
    endtask

    // mode: 0 plain, 1 zero write mid-frame, 2 new config mid-frame
    task automatic wen_op(int mode);
        logic [1:0] s0; logic ok, prev;
        logic [7:0] rx; int cs_low, rises, wrong, clr_at; bit err_seen;
        ok = exp_ok(m_en, m_sel); s0 = m_sel;
        rx = '0; cs_low = 0; rises = 0; wrong = 0; clr_at = -1; err_seen = 0; prev = 1'b0;
        reg_write(exp_rd(m_en, m_sel, 1'b1));
        chk("R8 bit set after write", 32'(reg_rdata[8]), 32'd1);
        for (int c = 0; c < 200; c++) begin
            if (spi_cs_n != 2'b11) begin
                cs_low++;
                if (spi_cs_n != exp_cs(s0)) wrong++;
            end
            if (spi_sck && !prev) begin rises++; rx = {rx[6:0], spi_mosi}; end
            prev = spi_sck;
            if (bus_err) err_seen = 1;
            if (c == 6 && mode == 1 && ok)
                chk("R9 zero write keeps bit", 32'(reg_rdata[8]), 32'd1);
            if (!reg_rdata[8]) begin clr_at = c; break; end
            if (c == 4 && mode != 0 && ok) begin
                if (mode == 2) begin m_en = 2'($urandom); m_sel = ~s0; end
                reg_wr = 1'b1; reg_wdata = exp_rd(m_en, m_sel, 1'b0);
            end else begin
                reg_wr = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
        chk("R10 no error for command", 32'(err_seen), 32'd0);
        if (ok) begin
            chk("R7 byte", 32'(rx), 32'h06);
            chk("R7 sck edges", 32'(rises), 32'd8);
            chk("R7 cs low length", 32'(cs_low), 32'(FRAME));
            chk("R4 R6 right bank only", 32'(wrong), 32'd0);
            chk("R8 clear cycle", 32'(clr_at), 32'(FRAME + 1));
        end else begin
            chk("R10 no cs", 32'(cs_low), 32'd0);
            chk("R10 no sck", 32'(rises), 32'd0);
            chk("R10 clear cycle", 32'(clr_at), 32'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rdata", reg_rdata, 32'h1);
        chk("R1 reset cs", 32'(spi_cs_n), 32'h3);
        chk("R1 reset sck", 32'(spi_sck), 32'd0);
        chk("R1 reset busy", 32'(bus_busy), 32'd0);
        chk("R1 reset err", 32'(bus_err), 32'd0);
        m_en = 2'b01; m_sel = 2'b00;
        bus_op(0);                      // R3 bank 0 as after reset
        set_cfg(2'b01, 2'b01); bus_op(0);   // R5 disabled bank 1
        set_cfg(2'b11, 2'b10); bus_op(0);   // R5 unimplemented code
        set_cfg(2'b11, 2'b11); bus_op(0);   // R5 unimplemented code
        set_cfg(2'b11, 2'b01); bus_op(1);   // R6 write mid transfer
        set_cfg(2'b11, 2'b01); wen_op(0);   // R7 bank 1 frame
        set_cfg(2'b01, 2'b00); wen_op(1);   // R9 zero write mid frame
        set_cfg(2'b11, 2'b00); wen_op(2);   // R6 new config mid frame
        set_cfg(2'b10, 2'b00); wen_op(0);   // R10 disabled bank
        set_cfg(2'b11, 2'b11); wen_op(0);   // R10 unimplemented code
        for (int i = 0; i < 40; i++) begin
            set_cfg(2'($urandom), 2'($urandom));
            if ($urandom % 2 == 0) bus_op(bit'($urandom));
            else wen_op(int'($urandom % 3));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule